// File: doc/BRIEF.md
# Disk Controller Command Phase Sequencer

This block is the host-facing sequencer of a floppy-style disk controller. It steps each command through up to three phases: a command phase in which the host writes the opcode and its parameter bytes, an execution phase run by an external engine, and a result phase in which the host reads status bytes back. An 8-bit status register, readable at any time with no wait state, tells the host whether it may touch the byte-wide data port and in which direction.

A small built-in table gives each opcode's byte counts. Seek takes 3 command bytes and returns no result. Recalibrate takes 2 bytes and returns no result. A generic read takes 9 bytes, runs an execution phase, then returns 7 result bytes. Any other opcode goes straight to a 1-byte result phase that returns an invalid-command code. For the two commands without a result phase, the engine carries on with the head motion in the background. It reports this motion through per-drive seek flags, which the status register mirrors.

Top module: `fdc_phase_seq`

## Requirements
- R1: After synchronous reset, with `drv_seek` = 0, `msr` reads 8'h80: ready bit (bit 7) = 1, direction bit (bit 6) = 0, and bits 5..0 = 0.
- R2: `msr[1:0]` follow `drv_seek[1:0]` (bit 0 = drive 0, bit 1 = drive 1) in every phase. `msr[3:2]` are always 0.
- R3: In the execution phase, `msr[7]` = 0 and data port writes and reads are ignored: the phase and the status do not change until `exec_done`.
- R4: `msr[6]` = 1 exactly in the result phase, where `msr[7]` = 1. `msr[6]` is 0 in the idle and command phases.
- R5: Busy (`msr[4]`) becomes 1 in the cycle after the first command byte is accepted, and stays 1 through the command phase. A status read in that cycle sees the new value.
- R6: For a command with a result phase, busy stays 1 until the last result byte is read, and then returns to 0. The sequencer is then back at idle (`msr` = 8'h80).
- R7: Seek (opcode 8'h0F, 3 bytes) and recalibrate (opcode 8'h07, 2 bytes) return busy to 0 right after their last command byte, with no execution or result phase.
- R8: `msr[5]` equals `polled_mode` during the execution phase and is 0 in every other phase.
- R9: A data port read in the idle or command phase, or a write in the result phase, is ignored: the byte count does not advance and the phase does not change.
- R10: An opcode outside the table enters a 1-byte result phase right after it is accepted. That byte reads 8'h80, and the sequencer returns to idle after it.
- R11: During the result phase of a table command, `host_rdata` equals `res_data`, and `res_index` counts 0, 1, ... up to the result count minus 1 as bytes are read.
- R12: `exec_go` pulses high for one cycle after the last command byte of seek, recalibrate or read is accepted, with `cmd_opcode` holding the opcode. A read command leaves the execution phase only on `exec_done`, which moves it to the result phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| polled_mode | input | 1 | Polled (non-DMA) transfer mode selected |
| host_wr | input | 1 | One-cycle data port write strobe |
| host_rd | input | 1 | One-cycle data port read strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Result byte presented to the host |
| msr | output | 8 | Main status register |
| drv_seek | input | 2 | Per-drive seek or recalibrate activity from the engine |
| exec_done | input | 1 | Engine signals the end of the execution phase |
| exec_go | output | 1 | One-cycle start pulse to the engine |
| cmd_opcode | output | 8 | Opcode of the current command |
| res_index | output | CW | Index of the result byte being read |
| res_data | input | 8 | Result byte supplied by the engine |

## Verification
The bench builds the block with its default parameters. These are a 4-bit byte counter and the three table opcodes 8'h0F, 8'h07 and 8'h06, so every command length the table defines, from 2 to 9 bytes and 0 to 7 results, is driven through to the end. The bench models the engine's result bytes as 8'hA0 plus the index, so a skipped or repeated index shows up as a wrong value. Polled mode is run both on and off, and strobes are placed in the wrong phase to show they do not shift the count.

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq #(
  parameter int CW = 4,
  parameter logic [7:0] OP_SEEK = 8'h0F,
  parameter logic [7:0] OP_RECAL = 8'h07,
  parameter logic [7:0] OP_READ = 8'h06,
  parameter logic [7:0] BAD_CODE = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          polled_mode,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic [7:0]    msr,
  input  logic [1:0]    drv_seek,
  input  logic          exec_done,
  output logic          exec_go,
  output logic [7:0]    cmd_opcode,
  output logic [CW-1:0] res_index,
  input  logic [7:0]    res_data
);
  typedef enum logic [1:0] {P_IDLE, P_CMD, P_EXEC, P_RES} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [7:0]    opc;
  logic          known;
  logic [CW-1:0] ncmd, nres;

  always_comb begin
    known = 1'b1;
    ncmd = CW'(1);
    nres = CW'(1);
    case (opc)
      OP_SEEK:  begin ncmd = CW'(3); nres = '0;     end
      OP_RECAL: begin ncmd = CW'(2); nres = '0;     end
      OP_READ:  begin ncmd = CW'(9); nres = CW'(7); end
      default:  known = 1'b0;
    endcase
  end

  wire rqm = (phase != P_EXEC);
  wire dio = (phase == P_RES);
  assign msr = {rqm, dio, (phase == P_EXEC) & polled_mode, phase != P_IDLE, 2'b00, drv_seek};
  assign host_rdata = known ? res_data : BAD_CODE;
  assign res_index = cnt;
  assign cmd_opcode = opc;

  wire bad_first = (host_wdata != OP_SEEK) && (host_wdata != OP_RECAL) && (host_wdata != OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= P_IDLE;
      cnt <= '0;
      opc <= '0;
      exec_go <= 1'b0;
    end else begin
      exec_go <= 1'b0;
      case (phase)
        P_IDLE: if (host_wr) begin
          opc <= host_wdata;
          if (bad_first) begin
            phase <= P_RES;
            cnt <= '0;
          end else begin
            phase <= P_CMD;
            cnt <= CW'(1);
          end
        end
        P_CMD: if (host_wr) begin
          if (cnt == ncmd - CW'(1)) begin
            exec_go <= 1'b1;
            cnt <= '0;
            phase <= (nres == '0) ? P_IDLE : P_EXEC;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        P_EXEC: if (exec_done) begin
          phase <= P_RES;
          cnt <= '0;
        end
        P_RES: if (host_rd) begin
          if (cnt == nres - CW'(1)) begin
            phase <= P_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(msr[4]) |-> $past(host_wr && msr[7] && !msr[6]));
  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(msr[4]) |-> $past((host_wr && !msr[6]) || (host_rd && msr[6])));
  assert_exec_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!msr[7] && !exec_done) |=> $stable(msr[7:4]));
  assert_ndma_R8: assert property (@(posedge clk) disable iff (rst)
    msr[5] |-> (!msr[7] && polled_mode));
  assert_dio_R4: assert property (@(posedge clk) disable iff (rst)
    msr[6] |-> (msr[7] && msr[4]));
  assert_go_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    exec_go |-> ($past(host_wr) && !$past(msr[6]) && $past(msr[4])));
  assert_go_single_R12: assert property (@(posedge clk) disable iff (rst)
    exec_go |=> !exec_go);
  assert_drv_bits_R2: assert property (@(posedge clk) disable iff (rst)
    msr[3:2] == 2'b00);
endmodule

// File: tb/sim_fdc_phase_seq.sv
module sim_fdc_phase_seq;
  logic clk = 0, rst = 1, polled_mode = 0, host_wr = 0, host_rd = 0, exec_done = 0;
  logic [7:0] host_wdata = 0;
  logic [1:0] drv_seek = 0;
  logic [7:0] host_rdata, msr, cmd_opcode, res_data;
  logic [3:0] res_index;
  logic exec_go;
  int checks = 0, failures = 0;
  logic go_seen;

  always #10 clk = ~clk;
  assign res_data = 8'hA0 + {4'h0, res_index};

  fdc_phase_seq u0 (.clk(clk), .rst(rst), .polled_mode(polled_mode), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata), .msr(msr),
    .drv_seek(drv_seek), .exec_done(exec_done), .exec_go(exec_go), .cmd_opcode(cmd_opcode),
    .res_index(res_index), .res_data(res_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); host_wr = 1; host_wdata = b;
    @(negedge clk); host_wr = 0; go_seen = exec_go;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); host_rd = 1; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset msr", msr, 8'h80);
    drv_seek = 2'b10; #1 chk("R2 drive1 bit", msr, 8'h82);
    drv_seek = 2'b01; #1 chk("R2 drive0 bit", msr, 8'h81);
    drv_seek = 2'b00;
  endtask

  task automatic t_seek;
    logic [7:0] v;
    rd(v); chk("R9 idle read ignored", msr, 8'h80);
    wr(8'h0F); chk("R5 busy after first byte", msr, 8'h90);
    wr(8'h01); chk("R5 busy mid command", msr, 8'h90);
    drv_seek = 2'b01;
    wr(8'h20); chk("R7 seek busy falls", msr, 8'h81);
    chk("R12 go after seek", {7'd0, go_seen}, 8'h01);
    chk("R12 opcode seek", cmd_opcode, 8'h0F);
    @(negedge clk); chk("R12 go single", {7'd0, exec_go}, 8'h00);
    drv_seek = 2'b00;
  endtask

  task automatic t_recal;
    wr(8'h07); chk("R5 recal busy", msr, 8'h90);
    wr(8'h00); chk("R7 recal busy falls", msr, 8'h80);
    chk("R12 go after recal", {7'd0, go_seen}, 8'h01);
  endtask

  task automatic t_read(logic pm);
    logic [7:0] v;
    polled_mode = pm;
    wr(8'h06); chk("R4 dio low in command", msr, 8'h90);
    rd(v); chk("R9 command read ignored", msr, 8'h90);
    for (int i = 0; i < 7; i++) wr(8'(i));
    chk("R9 still in command", msr, 8'h90);
    wr(8'hFF); chk("R8 exec status", msr, pm ? 8'h30 : 8'h10);
    chk("R12 go after read", {7'd0, go_seen}, 8'h01);
    wr(8'h33); chk("R3 exec write ignored", msr, pm ? 8'h30 : 8'h10);
    rd(v); chk("R3 exec read ignored", msr, pm ? 8'h30 : 8'h10);
    repeat (3) @(negedge clk);
    chk("R12 waits for done", msr, pm ? 8'h30 : 8'h10);
    exec_done = 1; @(negedge clk); exec_done = 0;
    chk("R4 result phase", msr, 8'hD0);
    wr(8'h44); chk("R9 result write ignored", msr, 8'hD0);
    for (int i = 0; i < 7; i++) begin
      rd(v); chk("R11 result byte", v, 8'hA0 + 8'(i));
      if (i < 6) chk("R6 busy holds", msr, 8'hD0);
    end
    chk("R6 idle after results", msr, 8'h80);
    polled_mode = 0;
  endtask

  task automatic t_bad;
    logic [7:0] v;
    wr(8'h55); chk("R10 bad enters result", msr, 8'hD0);
    chk("R10 no go", {7'd0, go_seen}, 8'h00);
    rd(v); chk("R10 invalid code", v, 8'h80);
    chk("R10 back to idle", msr, 8'h80);
  endtask

  initial begin
    #200_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_seek;
    t_recal;
    t_read(1'b1);
    t_read(1'b0);
    t_bad;
    t_recal;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule